// File: doc/BRIEF.md
# Triple Interval Timer with Clear-on-Read Event Counters

This block holds three independent interval timers for a small audio processor. Each timer counts pulses on its own prescale tick input. When the number of pulses it has counted equals the timer's programmed period, it records one event in a 4-bit event counter. Software reads an event counter through a byte-wide register port. The read returns the number of events since the previous read and sets that counter back to zero. Only software can zero a counter, so each event is counted once even when software polls it irregularly.

A separate control write strobe carries one run bit per timer. A timer restarts from zero only when its run bit goes from 0 to 1. Writing a run bit that is already 1 leaves the timer's counters alone, so software can update the control word at any time without disturbing running timers. The block does not generate the prescale ticks.

Top module: `timer_trio`

## Requirements
- R1: After a synchronous reset every event counter reads 0 and every timer is stopped: ticks arriving before the first control write leave the counts at 0.
- R2: A write to address 0xFA, 0xFB or 0xFC loads the 8-bit period of timer 0, 1 or 2. A read of any of these three addresses returns 0x00.
- R3: While a timer runs, each of its ticks advances an internal 8-bit divider. When the divider reaches the period, the divider returns to zero and the event counter increases by one. A timer with period P therefore logs one event per P ticks, and the divider keeps its partial progress between reads.
- R4: A period value of 0 acts as 256: the first event comes after 256 ticks.
- R5: The event counter is 4 bits wide and wraps modulo 16. Read data carries the count in bits 3:0 and zeros in bits 7:4.
- R6: A read of 0xFD, 0xFE or 0xFF (timer 0, 1, 2) places that timer's event count on rd_data on the clock edge that samples rd_en. The same edge clears the count.
- R7: If a read-clear and a new event fall on the same edge, the read returns the old count and the counter becomes 1.
- R8: Bits 0, 1 and 2 of the control word run timers 0, 1 and 2. A 0-to-1 change of a run bit clears both the divider and the event counter of that timer.
- R9: Writing the control word with a run bit that is already 1 clears neither counter of that timer.
- R10: While a timer is stopped, it ignores ticks and keeps both its divider and its event count.
- R11: Writes to 0xFD, 0xFE and 0xFF have no effect on the counters.
- R12: A tick on one timer's input does not change the other timers.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Registered read data, valid the cycle after rd_en |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_run | input | 3 | Run bit per timer, sampled with ctrl_we |
| tick | input | 3 | Prescale tick per timer, one pulse per clock |

## Verification
The bench aims at the edge where a read-clear and a new event land together. A design that gives the clear priority would drop that event and read 0 afterwards. It also rewrites the control word while a timer has a partial divider count. A design that restarts on level rather than on edge would delay the next event and read 0 where 1 is due. A period of 0 is run for 255 and then 256 ticks to catch a divider that fires at zero or never fires. Seventeen single-tick events check the 4-bit wrap and that the upper nibble stays zero. Stopped timers, and writes to the count addresses, must leave earlier counts readable as they were.

// File: rtl/timer_trio_pkg.sv
package timer_trio_pkg;
  localparam int unsigned NUM_TMR  = 3;
  localparam int unsigned DIV_W    = 8;
  localparam int unsigned EVT_W    = 4;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 8;
  localparam logic [7:0]  PER_BASE = 8'hFA;
  localparam logic [7:0]  EVT_BASE = 8'hFD;
endpackage

// File: rtl/timer_trio_decode.sv
module timer_trio_decode #(
  parameter int unsigned NUM_TMR  = 3,
  parameter int unsigned ADDR_W   = 8,
  parameter logic [ADDR_W-1:0] PER_BASE = 'hFA,
  parameter logic [ADDR_W-1:0] EVT_BASE = 'hFD
) (
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_TMR-1:0] per_we,
  output logic [NUM_TMR-1:0] evt_rd
);
  for (genvar g = 0; g < NUM_TMR; g++) begin : g_dec
    localparam logic [ADDR_W-1:0] PER_A = ADDR_W'(PER_BASE + g);
    localparam logic [ADDR_W-1:0] EVT_A = ADDR_W'(EVT_BASE + g);
    assign per_we[g] = wr_en && (addr == PER_A);
    assign evt_rd[g] = rd_en && (addr == EVT_A);
  end
endmodule

// File: rtl/timer_trio_chan.sv
module timer_trio_chan #(
  parameter int unsigned DIV_W = 8,
  parameter int unsigned EVT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             ctrl_we,
  input  logic             run_bit,
  input  logic             per_we,
  input  logic [DIV_W-1:0] per_data,
  input  logic             evt_clr,
  output logic [EVT_W-1:0] evt_cnt,
  output logic             running,
  output logic             evt_hit
);
  logic [DIV_W-1:0] period_q;
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] div_nxt;
  logic [EVT_W-1:0] evt_q;
  logic             run_q;
  logic             restart;

  // Divider wraps at 2^DIV_W, so a zero period matches after a full lap.
  assign div_nxt = div_q + DIV_W'(1);
  assign restart = ctrl_we && run_bit && !run_q;
  assign evt_hit = run_q && tick && !restart && (div_nxt == period_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      period_q <= '0;
      div_q    <= '0;
      evt_q    <= '0;
      run_q    <= 1'b0;
    end else begin
      if (per_we) period_q <= per_data;
      if (ctrl_we) run_q <= run_bit;
      if (restart) begin
        div_q <= '0;
        evt_q <= '0;
      end else begin
        if (run_q && tick) div_q <= evt_hit ? '0 : div_nxt;
        if (evt_clr)      evt_q <= evt_hit ? EVT_W'(1) : '0;
        else if (evt_hit) evt_q <= evt_q + EVT_W'(1);
      end
    end
  end

  assign evt_cnt = evt_q;
  assign running = run_q;
endmodule

// File: rtl/timer_trio_rdmux.sv
module timer_trio_rdmux #(
  parameter int unsigned NUM_TMR = 3,
  parameter int unsigned EVT_W   = 4,
  parameter int unsigned DATA_W  = 8
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          rd_en,
  input  logic [NUM_TMR-1:0]            evt_rd,
  input  logic [NUM_TMR-1:0][EVT_W-1:0] evt_cnt,
  output logic [DATA_W-1:0]             rd_data
);
  logic [DATA_W-1:0] sel_d;
  logic [DATA_W-1:0] rd_q;

  always_comb begin
    sel_d = '0;
    for (int i = 0; i < NUM_TMR; i++)
      if (evt_rd[i]) sel_d = DATA_W'(evt_cnt[i]);
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_q <= '0;
    else if (rd_en) rd_q <= sel_d;
  end

  assign rd_data = rd_q;
endmodule

// File: rtl/timer_trio.sv
module timer_trio
  import timer_trio_pkg::*;
#(
  parameter int unsigned N_TMR = NUM_TMR,
  parameter int unsigned DW    = DIV_W,
  parameter int unsigned EW    = EVT_W,
  parameter int unsigned AW    = ADDR_W,
  parameter int unsigned BW    = DATA_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          rd_en,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] wr_data,
  output logic [BW-1:0] rd_data,
  input  logic          ctrl_we,
  input  logic [N_TMR-1:0] ctrl_run,
  input  logic [N_TMR-1:0] tick
);
  logic [N_TMR-1:0]         per_we;
  logic [N_TMR-1:0]         evt_rd;
  logic [N_TMR-1:0][EW-1:0] evt_cnt;
  logic [N_TMR-1:0]         run_vec;
  logic [N_TMR-1:0]         hit_vec;

  timer_trio_decode #(
    .NUM_TMR(N_TMR), .ADDR_W(AW),
    .PER_BASE(AW'(PER_BASE)), .EVT_BASE(AW'(EVT_BASE))
  ) u_dec (
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .per_we(per_we), .evt_rd(evt_rd)
  );

  for (genvar g = 0; g < N_TMR; g++) begin : g_chan
    timer_trio_chan #(.DIV_W(DW), .EVT_W(EW)) u_chan (
      .clk(clk), .rst(rst), .tick(tick[g]),
      .ctrl_we(ctrl_we), .run_bit(ctrl_run[g]),
      .per_we(per_we[g]), .per_data(DW'(wr_data)),
      .evt_clr(evt_rd[g]), .evt_cnt(evt_cnt[g]),
      .running(run_vec[g]), .evt_hit(hit_vec[g])
    );
  end

  timer_trio_rdmux #(.NUM_TMR(N_TMR), .EVT_W(EW), .DATA_W(BW)) u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .evt_rd(evt_rd),
    .evt_cnt(evt_cnt), .rd_data(rd_data)
  );
endmodule

// File: rtl/timer_trio_chk.sv
module timer_trio_chk #(
  parameter int unsigned N_TMR = 3,
  parameter int unsigned EW    = 4,
  parameter int unsigned AW    = 8,
  parameter int unsigned BW    = 8
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     rd_en,
  input logic [AW-1:0]            addr,
  input logic [BW-1:0]            rd_data,
  input logic                     ctrl_we,
  input logic [N_TMR-1:0]         ctrl_run,
  input logic [N_TMR-1:0][EW-1:0] evt_cnt,
  input logic [N_TMR-1:0]         run_vec,
  input logic [N_TMR-1:0]         hit_vec
);
  // R5: upper nibble of read data is always zero
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    rd_data[BW-1:EW] == '0);

  for (genvar g = 0; g < N_TMR; g++) begin : g_chk
    localparam logic [AW-1:0] EA = AW'(timer_trio_pkg::EVT_BASE + g);

    // R6: read returns the pre-edge count
    a_r6_read_value: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == EA) |=> rd_data == BW'($past(evt_cnt[g])));

    // R7: after a read the count is 1 only if an event coincided
    a_r7_clear_keeps_hit: assert property (@(posedge clk) disable iff (rst)
      (rd_en && addr == EA && !ctrl_we) |=> evt_cnt[g] == EW'($past(hit_vec[g])));

    // R8: rising run bit restarts the counter
    a_r8_restart: assert property (@(posedge clk) disable iff (rst)
      (ctrl_we && ctrl_run[g] && !run_vec[g]) |=> (evt_cnt[g] == '0 && run_vec[g]));

    // R10: stopped timer keeps its count
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
      (!run_vec[g] && !ctrl_we && !(rd_en && addr == EA)) |=> $stable(evt_cnt[g]));

    // R3: count steps by at most one per edge without read or control
    a_r3_single_step: assert property (@(posedge clk) disable iff (rst)
      (!ctrl_we && !rd_en) |=>
        (evt_cnt[g] == $past(evt_cnt[g]) || evt_cnt[g] == $past(evt_cnt[g]) + EW'(1)));
  end
endmodule

bind timer_trio timer_trio_chk #(.N_TMR(N_TMR), .EW(EW), .AW(AW), .BW(BW)) u_chk (
  .clk(clk), .rst(rst), .rd_en(rd_en), .addr(addr), .rd_data(rd_data),
  .ctrl_we(ctrl_we), .ctrl_run(ctrl_run), .evt_cnt(evt_cnt),
  .run_vec(run_vec), .hit_vec(hit_vec)
);

// File: tb/timer_trio_bench.sv
module timer_trio_bench;
  localparam time TCK = 4ns;
  localparam logic [1:0] OP_WR = 2'd0, OP_RD = 2'd1, OP_CT = 2'd2, OP_TK = 2'd3;
  localparam int NV = 47;
  // {op, addr_or_mask, data_or_count, expected}
  localparam logic [25:0] VEC [NV] = '{
    {OP_RD, 8'hFD, 8'd0, 8'h00},   // R1 reset count
    {OP_RD, 8'hFE, 8'd0, 8'h00},   // R1
    {OP_RD, 8'hFF, 8'd0, 8'h00},   // R1
    {OP_WR, 8'hFA, 8'd3, 8'h00},   // R2 period t0
    {OP_WR, 8'hFB, 8'd5, 8'h00},   // R2 period t1
    {OP_WR, 8'hFC, 8'd2, 8'h00},   // R2 period t2
    {OP_RD, 8'hFA, 8'd0, 8'h00},   // R2 reads zero
    {OP_RD, 8'hFC, 8'd0, 8'h00},   // R2
    {OP_CT, 8'h00, 8'd7, 8'h00},   // R8 start all
    {OP_TK, 8'h07, 8'd6, 8'h00},   // R3 six ticks
    {OP_RD, 8'hFD, 8'd0, 8'h02},   // R3 6/3
    {OP_RD, 8'hFD, 8'd0, 8'h00},   // R6 cleared
    {OP_RD, 8'hFE, 8'd0, 8'h01},   // R3 6/5
    {OP_RD, 8'hFF, 8'd0, 8'h03},   // R3 6/2
    {OP_TK, 8'h01, 8'd3, 8'h00},   // R12 only t0
    {OP_RD, 8'hFE, 8'd0, 8'h00},   // R12 t1 untouched
    {OP_TK, 8'h02, 8'd4, 8'h00},   // R3 divider kept 1+4
    {OP_RD, 8'hFE, 8'd0, 8'h01},   // R3
    {OP_WR, 8'hFD, 8'h55, 8'h00},  // R11 ignored write
    {OP_RD, 8'hFD, 8'd0, 8'h01},   // R11
    {OP_TK, 8'h01, 8'd2, 8'h00},   // R9 partial divider
    {OP_CT, 8'h00, 8'd7, 8'h00},   // R9 rewrite set bit
    {OP_TK, 8'h01, 8'd1, 8'h00},   // R9
    {OP_RD, 8'hFD, 8'd0, 8'h01},   // R9 no restart
    {OP_TK, 8'h01, 8'd1, 8'h00},   // R8 divider 1
    {OP_CT, 8'h00, 8'd6, 8'h00},   // R10 stop t0
    {OP_TK, 8'h01, 8'd5, 8'h00},   // R10 ignored
    {OP_RD, 8'hFD, 8'd0, 8'h00},   // R10
    {OP_CT, 8'h00, 8'd7, 8'h00},   // R8 rising restart
    {OP_TK, 8'h01, 8'd2, 8'h00},   // R8
    {OP_RD, 8'hFD, 8'd0, 8'h00},   // R8 divider cleared
    {OP_TK, 8'h01, 8'd1, 8'h00},   // R8
    {OP_RD, 8'hFD, 8'd0, 8'h01},   // R8
    {OP_TK, 8'h04, 8'd2, 8'h00},   // R10 t2 one event
    {OP_CT, 8'h00, 8'd3, 8'h00},   // R10 stop t2
    {OP_TK, 8'h04, 8'd4, 8'h00},   // R10
    {OP_RD, 8'hFF, 8'd0, 8'h01},   // R10 count held
    {OP_WR, 8'hFA, 8'd1, 8'h00},   // R5 period 1
    {OP_TK, 8'h01, 8'd17, 8'h00},  // R5 seventeen events
    {OP_RD, 8'hFD, 8'd0, 8'h01},   // R5 wrap
    {OP_WR, 8'hFB, 8'd0, 8'h00},   // R4 period 0
    {OP_CT, 8'h00, 8'd1, 8'h00},   // R4 stop t1
    {OP_CT, 8'h00, 8'd3, 8'h00},   // R4 restart t1
    {OP_TK, 8'h02, 8'd255, 8'h00}, // R4
    {OP_RD, 8'hFE, 8'd0, 8'h00},   // R4 not yet
    {OP_TK, 8'h02, 8'd1, 8'h00},   // R4
    {OP_RD, 8'hFE, 8'd0, 8'h01}    // R4 at 256
  };

  logic clk = 1'b0, rst = 1'b1;
  logic wr_en = 0, rd_en = 0, ctrl_we = 0;
  logic [7:0] addr = 0, wr_data = 0;
  logic [2:0] ctrl_run = 0, tick = 0;
  logic [7:0] rd_data;
  int n_run = 0, n_fail = 0;

  always #(TCK/2) clk = ~clk;

  timer_trio u_timer_trio (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data), .ctrl_we(ctrl_we),
    .ctrl_run(ctrl_run), .tick(tick)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_run++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1; addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic do_ctrl(input logic [2:0] r);
    ctrl_we = 1; ctrl_run = r;
    @(negedge clk); ctrl_we = 0;
  endtask

  task automatic do_ticks(input logic [2:0] m, input int n);
    for (int k = 0; k < n; k++) begin
      tick = m; @(negedge clk);
    end
    tick = 0;
  endtask

  task automatic do_read(input logic [7:0] a, output logic [7:0] v);
    rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; v = rd_data;
  endtask

  initial begin
    #(TCK * 200000);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      case (VEC[i][25:24])
        OP_WR: do_write(VEC[i][23:16], VEC[i][15:8]);
        OP_CT: do_ctrl(VEC[i][10:8]);
        OP_TK: do_ticks(VEC[i][18:16], int'(VEC[i][15:8]));
        default: begin
          do_read(VEC[i][23:16], v);
          check($sformatf("vector %0d", i), v, VEC[i][7:0]);
        end
      endcase
    end

    // R7: read-clear and event on the same edge (t0 period 1, running)
    do_read(8'hFD, v);
    check("R7 pre-clear", v, 8'h00);
    do_ticks(3'b001, 3);
    rd_en = 1; addr = 8'hFD; tick = 3'b001;
    @(negedge clk); rd_en = 0; tick = 0;
    check("R7 old count", rd_data, 8'h03);
    do_read(8'hFD, v);
    check("R7 event kept", v, 8'h01);

    // R1: reset in mid-run clears counts and stops timers
    do_ticks(3'b001, 2);
    rst = 1; repeat (2) @(negedge clk); rst = 0;
    do_ticks(3'b111, 4);
    do_read(8'hFD, v);
    check("R1 t0 after reset", v, 8'h00);
    do_read(8'hFF, v);
    check("R1 t2 after reset", v, 8'h00);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule